// File: doc/BRIEF.md
# RGB video output level encoder

This block forms the digital output levels of a three-channel video converter. On every rising clock edge it takes in a red, a green and a blue colour word, together with an active-low blanking control and a composite sync control. One cycle later it presents six integer current codes in converter LSB units: a true code and a complementary code for each colour. The analog stage downstream turns these codes into currents. That stage, together with its reference and scaling, lies outside this block.

Composite sync is carried on the green true output only, as a fixed pedestal added on top of the video value. The complementary outputs follow full scale minus the video value and never carry the pedestal. Blanking zeroes the video value of all three channels. It does not change the sync term, so the blanking, sync and white levels can all be produced exactly.

An active-low power-save input forces all six codes to zero and freezes the capture register. The pixel stream runs continuously at the pixel clock and has no handshake. Every input is sampled on every edge, and no input can stall the stream.

Top module: `vdac_level_encoder`

## Requirements
- R1: All colour bits and both controls are captured together on the same rising edge. The outputs then reflect that capture, and only that capture, until the next edge: a latency of exactly one cycle.
- R2: With blank_n=1 and sync=0, red_o, green_o and blue_o equal the captured red, green and blue words.
- R3: With blank_n=1 and sync=1, green_o equals the green word plus PED (default 98), and red_o and blue_o are unchanged. White with sync gives green_o=255+98=353, which needs a 9-bit green_o.
- R4: With blank_n=0 the colour words are ignored. red_o and blue_o are 0, and all three complementary outputs are 255. green_o is PED if sync=1 and 0 if sync=0.
- R5: Each complementary output equals 255 minus that channel's video value (the word when blank_n=1, otherwise 0). green_c_o never includes the pedestal.
- R6: A synchronous active-high rst gives a state equal to blank_n=0, sync=0 after the edge. All true outputs are 0 and all complementary outputs are 255.
- R7: If psave_n=0 is sampled at an edge, all six outputs are 0 after that edge and the capture register keeps its contents. At the first edge that samples psave_n=1, normal capture resumes with one-cycle latency.
- R8: Bit 0 of each colour word is the least significant bit. A word of 0x01 gives a true code of 1, and 0x80 gives 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| psave_n | input | 1 | Power save, active low |
| blank_n | input | 1 | Blanking control, active low |
| sync | input | 1 | Composite sync, 1 adds the pedestal to green |
| red_in | input | DW (8) | Red colour word, bit 0 is the LSB |
| green_in | input | DW (8) | Green colour word, bit 0 is the LSB |
| blue_in | input | DW (8) | Blue colour word, bit 0 is the LSB |
| red_o | output | DW (8) | Red true current code |
| green_o | output | GW (9) | Green true current code, including the sync pedestal |
| blue_o | output | DW (8) | Blue true current code |
| red_c_o | output | DW (8) | Red complementary code |
| green_c_o | output | DW (8) | Green complementary code, without the pedestal |
| blue_c_o | output | DW (8) | Blue complementary code |

## Verification
The bench builds the block with its default parameters, DW=8 and PED=98. With these values, white with sync reaches a green code of 353, so the ninth green bit is exercised. A pedestal carry into that bit would be lost if the adder were too narrow. The scoreboard also runs a long pseudo-random mix of controls and colour words. This brings every combination of blanking, sync and power save within reach, including power-save entry and release between different colour words.

// File: rtl/vdac_pkg.sv
`timescale 1ns/1ps
package vdac_pkg;
  localparam int NUM_CH = 3;

  typedef enum int {
    CH_RED = 0,
    CH_GRN = 1,
    CH_BLU = 2
  } chan_e;
endpackage

// File: rtl/vdac_capture.sv
`timescale 1ns/1ps
module vdac_capture
  import vdac_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       psave_n,
  input  logic                       blank_n,
  input  logic                       sync,
  input  logic [NUM_CH-1:0][DW-1:0]  pix_in,
  output logic [NUM_CH-1:0][DW-1:0]  pix_q,
  output logic                       blank_q,
  output logic                       sync_q,
  output logic                       active_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_q    <= '0;
      blank_q  <= 1'b0;
      sync_q   <= 1'b0;
      active_q <= 1'b1;
    end else if (!psave_n) begin
      active_q <= 1'b0;
    end else begin
      pix_q    <= pix_in;
      blank_q  <= blank_n;
      sync_q   <= sync;
      active_q <= 1'b1;
    end
  end

  AST_HOLD_IN_PSAVE: assert property (@(posedge clk) disable iff (rst)
    (!psave_n) |=> ($stable(pix_q) && $stable(blank_q) && $stable(sync_q))); // R7
endmodule

// File: rtl/vdac_channel.sv
`timescale 1ns/1ps
module vdac_channel #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] pix_q,
  input  logic          blank_q,
  input  logic          active_q,
  output logic [DW-1:0] video_o,
  output logic [DW-1:0] comp_o
);
  localparam logic [DW-1:0] FULL = {DW{1'b1}};

  logic [DW-1:0] vid_raw;

  always_comb begin
    vid_raw = blank_q ? pix_q : '0;
    if (active_q) begin
      video_o = vid_raw;
      comp_o  = FULL - vid_raw;
    end else begin
      video_o = '0;
      comp_o  = '0;
    end
  end

  AST_BLANKED_CHANNEL: assert property (@(posedge clk) disable iff (rst)
    (active_q && !blank_q) |-> (video_o == '0 && comp_o == FULL)); // R4
endmodule

// File: rtl/vdac_sync_add.sv
`timescale 1ns/1ps
module vdac_sync_add #(
  parameter int DW  = 8,
  parameter int GW  = 9,
  parameter int PED = 98
) (
  input  logic [DW-1:0] video_g,
  input  logic          sync_q,
  input  logic          active_q,
  output logic [GW-1:0] green_o
);
  localparam logic [GW-1:0] PED_C = GW'(PED);

  always_comb begin
    green_o = GW'(video_g);
    if (active_q && sync_q) green_o = green_o + PED_C;
  end
endmodule

// File: rtl/vdac_level_encoder.sv
`timescale 1ns/1ps
module vdac_level_encoder
  import vdac_pkg::*;
#(
  parameter int DW  = 8,
  parameter int PED = 98,
  localparam int FULL = (1 << DW) - 1,
  localparam int GW   = $clog2(FULL + PED + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          psave_n,
  input  logic          blank_n,
  input  logic          sync,
  input  logic [DW-1:0] red_in,
  input  logic [DW-1:0] green_in,
  input  logic [DW-1:0] blue_in,
  output logic [DW-1:0] red_o,
  output logic [GW-1:0] green_o,
  output logic [DW-1:0] blue_o,
  output logic [DW-1:0] red_c_o,
  output logic [DW-1:0] green_c_o,
  output logic [DW-1:0] blue_c_o
);
  logic [NUM_CH-1:0][DW-1:0] pix_in;
  logic [NUM_CH-1:0][DW-1:0] pix_q;
  logic [NUM_CH-1:0][DW-1:0] video;
  logic [NUM_CH-1:0][DW-1:0] comp;
  logic blank_q, sync_q, active_q;

  assign pix_in[CH_RED] = red_in;
  assign pix_in[CH_GRN] = green_in;
  assign pix_in[CH_BLU] = blue_in;

  vdac_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst(rst), .psave_n(psave_n), .blank_n(blank_n), .sync(sync),
    .pix_in(pix_in), .pix_q(pix_q), .blank_q(blank_q), .sync_q(sync_q),
    .active_q(active_q)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    vdac_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst(rst), .pix_q(pix_q[i]), .blank_q(blank_q),
      .active_q(active_q), .video_o(video[i]), .comp_o(comp[i])
    );
  end

  vdac_sync_add #(.DW(DW), .GW(GW), .PED(PED)) u_sync (
    .video_g(video[CH_GRN]), .sync_q(sync_q), .active_q(active_q),
    .green_o(green_o)
  );

  assign red_o     = video[CH_RED];
  assign blue_o    = video[CH_BLU];
  assign red_c_o   = comp[CH_RED];
  assign green_c_o = comp[CH_GRN];
  assign blue_c_o  = comp[CH_BLU];

  AST_ONE_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (psave_n && blank_n && !sync) |=>
      (red_o == $past(red_in) && blue_o == $past(blue_in) &&
       green_o == GW'($past(green_in)))); // R1

  AST_SYNC_PEDESTAL: assert property (@(posedge clk) disable iff (rst)
    (psave_n && blank_n && sync) |=>
      (green_o == GW'($past(green_in)) + GW'(PED) && red_o == $past(red_in))); // R3

  AST_BLANK_LEVELS: assert property (@(posedge clk) disable iff (rst)
    (psave_n && !blank_n) |=>
      (red_o == '0 && blue_o == '0 && green_o == ($past(sync) ? GW'(PED) : '0))); // R4

  AST_COMP_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (psave_n && blank_n) |=>
      (int'(green_c_o) == FULL - int'($past(green_in)) &&
       int'(red_o) + int'(red_c_o) == FULL &&
       int'(blue_o) + int'(blue_c_o) == FULL)); // R5

  AST_PSAVE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!psave_n) |=>
      (red_o == '0 && green_o == '0 && blue_o == '0 &&
       red_c_o == '0 && green_c_o == '0 && blue_c_o == '0)); // R7
endmodule

// File: tb/vdac_level_encoder_test.sv
`timescale 1ns/1ps
module vdac_level_encoder_test;
  localparam int DW   = 8;
  localparam int PED  = 98;
  localparam int FULL = 255;
  localparam int GW   = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic psave_n = 1'b1, blank_n = 1'b0, sync = 1'b0;
  logic [DW-1:0] red_in = '0, green_in = '0, blue_in = '0;
  logic [DW-1:0] red_o, blue_o, red_c_o, green_c_o, blue_c_o;
  logic [GW-1:0] green_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] lfsr = 32'h1234_abcd;

  typedef struct {
    int r, g, b, rc, gc, bc;
    string tag;
  } exp_t;
  exp_t sb[$];

  always #2 clk = ~clk;

  vdac_level_encoder #(.DW(DW), .PED(PED)) uut (
    .clk(clk), .rst(rst), .psave_n(psave_n), .blank_n(blank_n), .sync(sync),
    .red_in(red_in), .green_in(green_in), .blue_in(blue_in),
    .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
    .red_c_o(red_c_o), .green_c_o(green_c_o), .blue_c_o(blue_c_o)
  );

  function automatic exp_t model(bit r_s, bit ps, bit bl, bit sy,
                                 int r, int g, int b, string tag);
    exp_t e;
    int vr, vg, vb;
    e.tag = tag;
    if (r_s) begin
      e.r = 0; e.g = 0; e.b = 0; e.rc = FULL; e.gc = FULL; e.bc = FULL;
    end else if (!ps) begin
      e.r = 0; e.g = 0; e.b = 0; e.rc = 0; e.gc = 0; e.bc = 0;
    end else begin
      vr = bl ? r : 0; vg = bl ? g : 0; vb = bl ? b : 0;
      e.r = vr; e.b = vb; e.g = vg + (sy ? PED : 0);
      e.rc = FULL - vr; e.gc = FULL - vg; e.bc = FULL - vb;
    end
    return e;
  endfunction

  task automatic drive(bit r_s, bit ps, bit bl, bit sy,
                       int r, int g, int b, string tag);
    @(negedge clk);
    rst = r_s; psave_n = ps; blank_n = bl; sync = sy;
    red_in = DW'(r); green_in = DW'(g); blue_in = DW'(b);
    sb.push_back(model(r_s, ps, bl, sy, r, g, b, tag));
  endtask

  always @(posedge clk) begin
    exp_t e;
    #1;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      checks++;
      if (int'(red_o) != e.r || int'(green_o) != e.g || int'(blue_o) != e.b ||
          int'(red_c_o) != e.rc || int'(green_c_o) != e.gc || int'(blue_c_o) != e.bc) begin
        failures++;
        $display("FAIL %s actual t=%0d/%0d/%0d c=%0d/%0d/%0d expected t=%0d/%0d/%0d c=%0d/%0d/%0d",
                 e.tag, red_o, green_o, blue_o, red_c_o, green_c_o, blue_c_o,
                 e.r, e.g, e.b, e.rc, e.gc, e.bc);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R6: reset state, with pixel data present that must not show
    drive(1, 1, 1, 1, 200, 150, 100, "R6");
    drive(1, 1, 1, 0, 55, 66, 77, "R6");
    // R8: LSB weighting
    drive(0, 1, 1, 0, 8'h01, 8'h01, 8'h01, "R8");
    drive(0, 1, 1, 0, 8'h80, 8'h02, 8'h40, "R8");
    // R2: active video patterns
    drive(0, 1, 1, 0, 255, 255, 255, "R2");
    drive(0, 1, 1, 0, 0, 0, 0, "R2");
    drive(0, 1, 1, 0, 17, 234, 99, "R2");
    // R1: back-to-back distinct words, one-cycle latency
    for (int i = 0; i < 8; i++) drive(0, 1, 1, 0, i * 31, 255 - i * 29, i * 7 + 3, "R1");
    // R3: sync pedestal, incl. white reaching 353
    drive(0, 1, 1, 1, 255, 255, 255, "R3");
    drive(0, 1, 1, 1, 10, 0, 20, "R3");
    drive(0, 1, 1, 1, 1, 157, 2, "R3");
    // R4: blanking ignores colour words
    drive(0, 1, 0, 1, 255, 255, 255, "R4");
    drive(0, 1, 0, 0, 123, 45, 67, "R4");
    drive(0, 1, 0, 1, 0, 0, 0, "R4");
    // R5: complementary never carries pedestal
    drive(0, 1, 1, 1, 100, 100, 100, "R5");
    drive(0, 1, 1, 0, 200, 1, 254, "R5");
    // R7: power save then release
    drive(0, 1, 1, 0, 90, 91, 92, "R7");
    drive(0, 0, 1, 1, 250, 250, 250, "R7");
    drive(0, 0, 0, 0, 3, 4, 5, "R7");
    drive(0, 1, 1, 0, 11, 22, 33, "R7");
    drive(0, 0, 1, 0, 44, 55, 66, "R7");
    drive(0, 1, 0, 1, 77, 88, 99, "R7");
    // R6: reset mid-stream
    drive(1, 1, 1, 1, 9, 9, 9, "R6");
    // mixed pseudo-random stream (R2 R3 R4 R5 R7)
    for (int i = 0; i < 300; i++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      drive(0, lfsr[31:29] != 3'b000, lfsr[28], lfsr[27],
            int'(lfsr[7:0]), int'(lfsr[15:8]), int'(lfsr[23:16]), "R5_mix");
    end
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule